// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is a single output cell of a programmable logic device. A bundle of product terms from the device's AND array is summed in an OR gate. The sum goes either straight to the cell output or through a D flip-flop first. The chosen value can be inverted before it reaches the pin. A feedback line returns either the flip-flop state or the raw OR sum to the array. The flip-flop state supports state machines. The raw OR sum lets a neighbouring cell borrow this cell's product terms.

The flip-flop has three selectable controls:
- Clock: the global clock (synchronous operation) or a dedicated product term (asynchronous operation).
- Asynchronous clear: the global reset or a dedicated product term.
- Asynchronous preset: driven only by a dedicated product term, and only when enabled.

The pin has four modes. Input mode hands the pin value to the array. Output mode always drives the pin. Bidirectional mode drives the pin under a product-term enable. Buried mode keeps the cell off the pin while feedback continues to work.

Top module: `pld_macrocell`

## Requirements
- R1: With combinational output selected and no inversion, `pinOut` equals the OR of all `ptIn` bits in the same cycle.
- R2: When `cfgInvert` is 1, `pinOut` is the complement of the selected source (OR sum or register).
- R3: With registered output and `cfgClkPt`=0, the register captures the OR sum on each rising `clk` edge and `pinOut` shows it after that edge.
- R4: `cfgPinMode` uses the encoding 00 input, 01 output, 10 bidirectional, 11 buried. `pinOe` is 1 in output mode, follows `ptOe` in bidirectional mode, and is 0 in input and buried modes.
- R5: `cfgFbComb`=1 makes `fbOut` equal the OR sum at once. `cfgFbComb`=0 makes `fbOut` the uninverted register state, which stays unchanged while `ptIn` moves and no clock edge arrives.
- R6: In buried mode `pinOe` is 0, and `fbOut` still follows the register, which keeps loading on its clock.
- R7: With `cfgClkPt`=1 the register loads only on a rising `ptClk`, and `clk` edges leave it unchanged.
- R8: With `cfgClrPt`=0, `rstN` low clears the register. With `cfgClrPt`=1, `rstN` has no effect on the register, and a high `ptClr` clears it asynchronously.
- R9: With `cfgPreEn`=1, a high `ptPre` sets the register to 1 asynchronously. With `cfgPreEn`=0, `ptPre` has no effect.
- R10: When clear and preset are both active, clear wins and the register holds 0.
- R11: `pinToArray` equals `pinIn` in input and bidirectional modes, and is 0 in output and buried modes.
- R12: After reset with `cfgClrPt`=0, the register is 0, so `fbOut` is 0 with register feedback and `pinOut` is 0 with registered, uninverted output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rstN | input | 1 | Global reset, active low |
| cfgInvert | input | 1 | Invert the output polarity |
| cfgRegOut | input | 1 | 1 selects the register output, 0 the OR sum |
| cfgPinMode | input | 2 | Pin mode: 00 in, 01 out, 10 bidir, 11 buried |
| cfgFbComb | input | 1 | 1 feeds back the OR sum, 0 the register |
| cfgClkPt | input | 1 | 1 clocks the register from `ptClk` |
| cfgClrPt | input | 1 | 1 clears from `ptClr` instead of `rstN` |
| cfgPreEn | input | 1 | Enables the product-term preset |
| ptIn | input | NUM_PT | Product terms summed by the OR gate |
| ptClk | input | 1 | Product-term clock |
| ptClr | input | 1 | Product-term clear |
| ptPre | input | 1 | Product-term preset |
| ptOe | input | 1 | Product-term output enable for bidirectional mode |
| pinIn | input | 1 | Value sensed on the pin |
| pinOut | output | 1 | Value to drive on the pin |
| pinOe | output | 1 | Pin driver enable |
| fbOut | output | 1 | Feedback to the AND array |
| pinToArray | output | 1 | Pin input value passed to the array |

## Verification
Clear and preset can be active in the same interval. The bench raises the product-term preset first, which sets the register, and then raises the product-term clear while preset stays high. The register must read 0 throughout the overlap, and a checker also samples this at clock edges. A second overlap involves the two clocks: the bench switches to the product-term clock while the global clock keeps running, then confirms that global edges leave the state unchanged and that only the `ptClk` edge loads it.

// File: rtl/macrocell_pkg.sv
package macrocell_pkg;

  typedef enum logic [1:0] {
    PIN_IN     = 2'b00,
    PIN_OUT    = 2'b01,
    PIN_BIDIR  = 2'b10,
    PIN_BURIED = 2'b11
  } pin_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic outReg;    // select register for output
    logic invert;    // output polarity
    logic fbReg;     // select register for feedback
    logic clkFromPt; // clock from product term
    logic clrAct;    // asynchronous clear level
    logic preAct;    // asynchronous preset level
    logic drivePin;  // pin driver enable
    logic readPin;   // pass pin value to array
  } mc_strobe_t;

endpackage

// File: rtl/macrocell_ctrl.sv
module macrocell_ctrl
  import macrocell_pkg::*;
(
  input  logic       rstN,
  input  logic       cfgInvert,
  input  logic       cfgRegOut,
  input  logic [1:0] cfgPinMode,
  input  logic       cfgFbComb,
  input  logic       cfgClkPt,
  input  logic       cfgClrPt,
  input  logic       cfgPreEn,
  input  logic       ptClr,
  input  logic       ptPre,
  input  logic       ptOe,
  output mc_strobe_t strobe
);

  pin_mode_e pinMode;
  logic      clrLevel;

  assign pinMode  = pin_mode_e'(cfgPinMode);
  assign clrLevel = cfgClrPt ? ptClr : ~rstN;

  always_comb begin
    strobe           = '0;
    strobe.outReg    = cfgRegOut;
    strobe.invert    = cfgInvert;
    strobe.fbReg     = ~cfgFbComb;
    strobe.clkFromPt = cfgClkPt;
    strobe.clrAct    = clrLevel;
    strobe.preAct    = cfgPreEn & ptPre;
    unique case (pinMode)
      PIN_IN: begin
        strobe.drivePin = 1'b0;
        strobe.readPin  = 1'b1;
      end
      PIN_OUT: begin
        strobe.drivePin = 1'b1;
        strobe.readPin  = 1'b0;
      end
      PIN_BIDIR: begin
        strobe.drivePin = ptOe;
        strobe.readPin  = 1'b1;
      end
      default: begin
        strobe.drivePin = 1'b0;
        strobe.readPin  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/macrocell_dp.sv
module macrocell_dp
  import macrocell_pkg::*;
#(
  parameter int NUM_PT = 10
) (
  input  logic              clk,
  input  mc_strobe_t        strobe,
  input  logic [NUM_PT-1:0] ptIn,
  input  logic              ptClk,
  input  logic              pinIn,
  output logic              pinOut,
  output logic              pinOe,
  output logic              fbOut,
  output logic              pinToArray
);

  logic orSum;
  logic ffClk;
  logic ffQ;
  logic srcSel;

  // OR plane: reduce the product-term bundle
  always_comb begin
    orSum = 1'b0;
    for (int i = 0; i < NUM_PT; i++) begin
      orSum = orSum | ptIn[i];
    end
  end

  assign ffClk = strobe.clkFromPt ? ptClk : clk;

  // Clear outranks preset
  always_ff @(posedge ffClk or posedge strobe.clrAct or posedge strobe.preAct) begin
    if (strobe.clrAct) begin
      ffQ <= 1'b0;
    end else if (strobe.preAct) begin
      ffQ <= 1'b1;
    end else begin
      ffQ <= orSum;
    end
  end

  assign srcSel     = strobe.outReg ? ffQ : orSum;
  assign pinOut     = srcSel ^ strobe.invert;
  assign pinOe      = strobe.drivePin;
  assign fbOut      = strobe.fbReg ? ffQ : orSum;
  assign pinToArray = strobe.readPin & pinIn;

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import macrocell_pkg::*;
#(
  parameter int NUM_PT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgInvert,
  input  logic              cfgRegOut,
  input  logic [1:0]        cfgPinMode,
  input  logic              cfgFbComb,
  input  logic              cfgClkPt,
  input  logic              cfgClrPt,
  input  logic              cfgPreEn,
  input  logic [NUM_PT-1:0] ptIn,
  input  logic              ptClk,
  input  logic              ptClr,
  input  logic              ptPre,
  input  logic              ptOe,
  input  logic              pinIn,
  output logic              pinOut,
  output logic              pinOe,
  output logic              fbOut,
  output logic              pinToArray
);

  mc_strobe_t strobe;

  macrocell_ctrl u_ctrl (
    .rstN       (rstN),
    .cfgInvert  (cfgInvert),
    .cfgRegOut  (cfgRegOut),
    .cfgPinMode (cfgPinMode),
    .cfgFbComb  (cfgFbComb),
    .cfgClkPt   (cfgClkPt),
    .cfgClrPt   (cfgClrPt),
    .cfgPreEn   (cfgPreEn),
    .ptClr      (ptClr),
    .ptPre      (ptPre),
    .ptOe       (ptOe),
    .strobe     (strobe)
  );

  macrocell_dp #(.NUM_PT(NUM_PT)) u_dp (
    .clk        (clk),
    .strobe     (strobe),
    .ptIn       (ptIn),
    .ptClk      (ptClk),
    .pinIn      (pinIn),
    .pinOut     (pinOut),
    .pinOe      (pinOe),
    .fbOut      (fbOut),
    .pinToArray (pinToArray)
  );

endmodule

// File: rtl/macrocell_chk.sv
module macrocell_chk #(
  parameter int NUM_PT = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgInvert,
  input logic              cfgRegOut,
  input logic [1:0]        cfgPinMode,
  input logic              cfgFbComb,
  input logic              cfgClkPt,
  input logic              cfgClrPt,
  input logic              cfgPreEn,
  input logic [NUM_PT-1:0] ptIn,
  input logic              ptClr,
  input logic              ptPre,
  input logic              ptOe,
  input logic              pinIn,
  input logic              pinOut,
  input logic              pinOe,
  input logic              fbOut,
  input logic              pinToArray
);

  logic syncReg;
  assign syncReg = cfgRegOut && !cfgInvert && !cfgClkPt && !cfgClrPt && !cfgPreEn;

  // R4
  pin_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinOe |-> (cfgPinMode == 2'b01 || (cfgPinMode == 2'b10 && ptOe)));

  // R6
  buried_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgPinMode == 2'b11) |-> !pinOe);

  // R5
  comb_fb_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgFbComb |-> (fbOut == (|ptIn)));

  // R11
  pin_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgPinMode == 2'b00) |-> (pinToArray == pinIn));

  // R3
  sync_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncReg && $past(syncReg)) |-> (pinOut == $past(|ptIn)));

  // R10
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgClrPt && ptClr && cfgPreEn && ptPre && !cfgFbComb) |-> !fbOut);

endmodule

bind pld_macrocell macrocell_chk #(.NUM_PT(NUM_PT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgInvert  (cfgInvert),
  .cfgRegOut  (cfgRegOut),
  .cfgPinMode (cfgPinMode),
  .cfgFbComb  (cfgFbComb),
  .cfgClkPt   (cfgClkPt),
  .cfgClrPt   (cfgClrPt),
  .cfgPreEn   (cfgPreEn),
  .ptIn       (ptIn),
  .ptClr      (ptClr),
  .ptPre      (ptPre),
  .ptOe       (ptOe),
  .pinIn      (pinIn),
  .pinOut     (pinOut),
  .pinOe      (pinOe),
  .fbOut      (fbOut),
  .pinToArray (pinToArray)
);

// File: tb/sim_pld_macrocell.sv
module sim_pld_macrocell;

  localparam int PERIOD = 10;
  localparam int NPT    = 10;
  localparam int NVEC   = 8;

  // {ptIn, invert, mode, ptOe, pinIn, expOut, expOe, expFb, expArr}
  localparam logic [18:0] VECS [NVEC] = '{
    {10'h000, 1'b0, 2'b01, 1'b0, 1'b0, 4'b0100},
    {10'h001, 1'b0, 2'b01, 1'b0, 1'b1, 4'b1110},
    {10'h200, 1'b1, 2'b01, 1'b0, 1'b0, 4'b0110},
    {10'h000, 1'b1, 2'b00, 1'b1, 1'b1, 4'b1001},
    {10'h0F0, 1'b0, 2'b10, 1'b1, 1'b0, 4'b1110},
    {10'h0F0, 1'b0, 2'b10, 1'b0, 1'b1, 4'b1011},
    {10'h3FF, 1'b1, 2'b11, 1'b1, 1'b1, 4'b0010},
    {10'h000, 1'b0, 2'b00, 1'b0, 1'b0, 4'b0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgInvert = 1'b0, cfgRegOut = 1'b0, cfgFbComb = 1'b0;
  logic [1:0] cfgPinMode = 2'b01;
  logic cfgClkPt = 1'b0, cfgClrPt = 1'b0, cfgPreEn = 1'b0;
  logic [NPT-1:0] ptIn = '0;
  logic ptClk = 1'b0, ptClr = 1'b0, ptPre = 1'b0, ptOe = 1'b0, pinIn = 1'b0;
  logic pinOut, pinOe, fbOut, pinToArray;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pld_macrocell #(.NUM_PT(NPT)) u0 (
    .clk(clk), .rstN(rstN), .cfgInvert(cfgInvert), .cfgRegOut(cfgRegOut),
    .cfgPinMode(cfgPinMode), .cfgFbComb(cfgFbComb), .cfgClkPt(cfgClkPt),
    .cfgClrPt(cfgClrPt), .cfgPreEn(cfgPreEn), .ptIn(ptIn), .ptClk(ptClk),
    .ptClr(ptClr), .ptPre(ptPre), .ptOe(ptOe), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .fbOut(fbOut), .pinToArray(pinToArray)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  initial begin
    #(PERIOD * 2000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    cfgRegOut = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 fbOut", fbOut, 1'b0);
    chk("R12 pinOut", pinOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    // R1 R2 R4 R11 R5: vector walk, combinational output and feedback
    cfgRegOut = 1'b0;
    cfgFbComb = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {ptIn, cfgInvert, cfgPinMode, ptOe, pinIn} = VECS[i][18:4];
      #1;
      chk("R1/R2 pinOut", pinOut, VECS[i][3]);
      chk("R4 pinOe", pinOe, VECS[i][2]);
      chk("R5 fbOut", fbOut, VECS[i][1]);
      chk("R11 pinToArray", pinToArray, VECS[i][0]);
    end

    // R3: registered output on global clock
    @(negedge clk);
    cfgRegOut = 1'b1; cfgFbComb = 1'b0; cfgInvert = 1'b0; cfgPinMode = 2'b01;
    ptIn = 10'h004;
    @(posedge clk); #1;
    chk("R3 load one", pinOut, 1'b1);
    @(negedge clk);
    ptIn = '0;
    #1;
    chk("R3 hold before edge", pinOut, 1'b1);
    @(posedge clk); #1;
    chk("R3 load zero", pinOut, 1'b0);
    @(negedge clk);
    cfgInvert = 1'b1;
    #1;
    chk("R2 inverted register", pinOut, 1'b1);
    cfgInvert = 1'b0;

    // R6: buried mode, feedback keeps loading
    @(negedge clk);
    cfgPinMode = 2'b11; ptIn = 10'h100;
    @(posedge clk); #1;
    chk("R6 pinOe", pinOe, 1'b0);
    chk("R6 fbOut", fbOut, 1'b1);
    @(negedge clk);
    ptIn = '0;
    @(posedge clk); #1;
    chk("R6 fbOut zero", fbOut, 1'b0);

    // R7: product-term clock
    @(negedge clk);
    cfgPinMode = 2'b01; cfgClkPt = 1'b1; ptIn = 10'h001;
    repeat (2) @(posedge clk);
    #1;
    chk("R7 clk ignored", fbOut, 1'b0);
    ptClk = 1'b1; #1;
    chk("R7 ptClk load", fbOut, 1'b1);
    ptClk = 1'b0;

    // R5: register feedback holds while ptIn moves
    @(negedge clk);
    cfgRegOut = 1'b0; ptIn = '0;
    #1;
    chk("R5 reg fb holds", fbOut, 1'b1);
    chk("R1 comb out follows", pinOut, 1'b0);
    cfgRegOut = 1'b1;

    // R8: clear source
    @(negedge clk);
    cfgClrPt = 1'b1;
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R8 rstN ignored", fbOut, 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    ptClr = 1'b1; #1;
    chk("R8 ptClr clears", fbOut, 1'b0);
    ptClr = 1'b0;

    // R9: preset enable
    @(negedge clk);
    ptPre = 1'b1; #1;
    chk("R9 preset disabled", fbOut, 1'b0);
    cfgPreEn = 1'b1; #1;
    chk("R9 preset sets", fbOut, 1'b1);

    // R10: clear beats preset while both held
    ptClr = 1'b1; #1;
    chk("R10 clear wins", fbOut, 1'b0);
    repeat (2) @(posedge clk);
    #1;
    chk("R10 clear still wins", fbOut, 1'b0);
    @(negedge clk);
    ptClr = 1'b0; ptPre = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule